// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block runs the digital side of a successive-approximation converter behind a small memory-mapped register file. Software selects an input channel and starts a conversion by writing the channel-control register. The block counts out the sampling and conversion phases in converter-clock periods, which it derives from the bus clock through a programmable prescaler. It captures one sample at the end of each base conversion and can average up to 32 samples in hardware. It then masks the result to the selected resolution, sets a completion flag and, when the interrupt is enabled, raises an interrupt.

The analog converter is not part of the block. A `sample_data` input port stands in for it, and `smp_take` pulses once after each capture so that whatever drives that port can move on to the next value. The block can also restart itself after every completion (continuous mode). It also runs a calibration request as a fixed-length sequence that ends with a pass/fail flag.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 (channel control), 0x08 (status), 0x0C (result), 0x14 (configuration), 0x18 (general control) and 0x1C (general status). A read of an offset that is not a multiple of 4, or of an offset above 0x30, raises `bus_err` and returns 0. Other unlisted aligned offsets read as 0.
- R2: Channel control holds the channel in bits [4:0] and the interrupt enable in bit 7, and resets to 0x1F. Writing a channel of 0x1F aborts any running conversion without setting the flag. Writing any other channel starts a conversion, restarting one that is already running.
- R3: A conversion completes 6 + N×(25+L) converter-clock periods after the write that starts it. One converter-clock period is 2^cfg[6:5] bus clocks, doubled when cfg[1:0] equals 1.
- R4: The adder L comes from cfg[4] and cfg[9:8]. With cfg[4]=0, field values 0..3 give 3, 5, 7 and 9. With cfg[4]=1, they give 13, 17, 21 and 25.
- R5: With general-control bit 5 set, N is 4, 8, 16 or 32 for cfg[15:14] = 0..3; otherwise N is 1. `sample_data` is captured at the end of each base period, and the result is the sum of the N samples shifted right by log2(N).
- R6: cfg[3:2] = 0, 1 or 2 masks the result to 8, 10 or 12 bits (0xFF, 0x3FF, 0xFFF). The value 3 is treated as 12 bits.
- R7: On completion, status bit 0 is set. `irq` is high while that flag is set and channel-control bit 7 is set.
- R8: A read of the result register clears the flag. When that read falls in the same cycle as a completion, the read returns the old result, and the flag stays set with the new result stored.
- R9: With cfg[16] clear, a completion that finds the flag set and unread leaves the old result in place. With cfg[16] set, the new result replaces it.
- R10: With general-control bit 6 set, the block starts a new conversion on the same channel in the cycle that the previous one completes. Writing channel 0x1F stops it.
- R11: Writing general-control bit 7 while idle runs calibration. This is 6 + 32×(25+L) converter-clock periods with `sample_data` ignored. At the end it sets the completion flag, clears general-status bit 1 and general-control bit 7, and leaves the result unchanged.
- R12: A calibration request made while a conversion or calibration is running sets general-status bit 1 and clears general-control bit 7. The running operation is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects occur at the clock edge) |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| bus_err | output | 1 | Rejected read |
| sample_data | input | DW | Stand-in for the converter output |
| smp_take | output | 1 | One-cycle pulse after each sample capture |
| irq | output | 1 | Completion interrupt |

## Verification
The two functions that can coincide are the flag-clearing read of the result register and the completion of a conversion. The bench starts a conversion while an unread result is pending and overwrite is disabled. It then places the result read exactly on the cycle whose clock edge completes the conversion. The read must return the old value, and after that edge the status flag must be set and the result register must hold the new sample. The rule is that the read consumes the old result, so the new one is stored even with overwrite disabled.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DW      = 12,
  parameter int AW      = 8,
  parameter int CAL_LOG = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_err,
  input  logic [DW-1:0] sample_data,
  output logic          smp_take,
  output logic          irq
);
  localparam int AccW = DW + 5;
  localparam logic [AW-1:0] A_CH = AW'(8'h00), A_ST = AW'(8'h08), A_RES = AW'(8'h0C),
                            A_CFG = AW'(8'h14), A_GC = AW'(8'h18), A_GS = AW'(8'h1C),
                            A_TOP = AW'(8'h30);

  logic [4:0]  chan;
  logic        aien, coco, calf;
  logic [16:0] cfg;
  logic [7:0]  gctl;
  logic [DW-1:0] result;

  logic        busy, cal_run, setup;
  logic [5:0]  pcnt, sidx, base_q;
  logic [2:0]  nlog_q, dexp_q;
  logic [1:0]  res_q;
  logic [4:0]  pre;
  logic [AccW-1:0] acc;

  logic [4:0] ladd;
  always_comb
    case ({cfg[4], cfg[9:8]})
      3'd0: ladd = 5'd3;
      3'd1: ladd = 5'd5;
      3'd2: ladd = 5'd7;
      3'd3: ladd = 5'd9;
      3'd4: ladd = 5'd13;
      3'd5: ladd = 5'd17;
      3'd6: ladd = 5'd21;
      default: ladd = 5'd25;
    endcase

  wire bad      = (bus_addr[1:0] != 2'b00) || (bus_addr > A_TOP);
  wire wr_ch    = bus_wr && bus_addr == A_CH;
  wire wr_cfg   = bus_wr && bus_addr == A_CFG;
  wire wr_gc    = bus_wr && bus_addr == A_GC;
  wire rd_res   = bus_rd && bus_addr == A_RES;
  wire ch_stop  = bus_wdata[4:0] == 5'h1F;
  wire start_cv = wr_ch && !ch_stop && !cal_run;
  wire stop_cv  = wr_ch && ch_stop && !cal_run;
  wire cal_req  = wr_gc && bus_wdata[7];
  wire start_cl = cal_req && !busy;

  wire [4:0] pre_lim  = (5'd1 << dexp_q) - 5'd1;
  wire       tick     = busy && pre == pre_lim;
  wire       end_base = tick && !setup && pcnt == base_q - 6'd1;
  wire       done     = end_base && sidx == (6'd1 << nlog_q) - 6'd1;
  wire       restart  = done && !cal_run && gctl[6] && chan != 5'h1F;
  wire       load     = start_cv || start_cl || (restart && !stop_cv);

  wire [AccW-1:0] acc_n = acc + AccW'(sample_data);
  wire [AccW-1:0] shifted = acc_n >> nlog_q;
  logic [DW-1:0] mask;
  always_comb
    case (res_q)
      2'd0:    mask = DW'(12'h0FF);
      2'd1:    mask = DW'(12'h3FF);
      default: mask = DW'(12'hFFF);
    endcase
  wire [DW-1:0] avg = shifted[DW-1:0] & mask;

  wire [2:0] nlog_n = start_cl ? 3'(CAL_LOG) : (gctl[5] ? 3'd2 + {1'b0, cfg[15:14]} : 3'd0);
  wire [2:0] dexp_n = {1'b0, cfg[6:5]} + {2'b00, cfg[1:0] == 2'd1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan <= 5'h1F; aien <= 1'b0; cfg <= '0; gctl <= '0;
      coco <= 1'b0; calf <= 1'b0; result <= '0;
      busy <= 1'b0; cal_run <= 1'b0; setup <= 1'b0;
      pcnt <= '0; sidx <= '0; base_q <= 6'd28; nlog_q <= '0; dexp_q <= '0;
      res_q <= '0; pre <= '0; acc <= '0; smp_take <= 1'b0;
    end else begin
      smp_take <= end_base && !cal_run;
      if (wr_ch) begin chan <= bus_wdata[4:0]; aien <= bus_wdata[7]; end
      if (wr_cfg) cfg <= bus_wdata[16:0];
      if (wr_gc) begin
        gctl[6:0] <= bus_wdata[6:0];
        gctl[7]   <= bus_wdata[7] && !busy;
        if (cal_req && busy) calf <= 1'b1;
      end
      if (rd_res) coco <= 1'b0;

      if (busy) pre <= tick ? '0 : pre + 5'd1;
      if (tick) begin
        if (setup) begin
          if (pcnt == 6'd5) begin setup <= 1'b0; pcnt <= '0; end
          else pcnt <= pcnt + 6'd1;
        end else if (end_base) begin
          pcnt <= '0;
          acc  <= acc_n;
          sidx <= sidx + 6'd1;
        end else pcnt <= pcnt + 6'd1;
      end

      if (done) begin
        busy <= 1'b0;
        coco <= 1'b1;
        if (cal_run) begin
          cal_run <= 1'b0; calf <= 1'b0; gctl[7] <= 1'b0;
        end else if (!coco || cfg[16] || rd_res) result <= avg;
      end

      if (load) begin
        busy <= 1'b1; cal_run <= start_cl; setup <= 1'b1;
        pcnt <= '0; sidx <= '0; pre <= '0; acc <= '0;
        base_q <= 6'd25 + {1'b0, ladd}; nlog_q <= nlog_n; dexp_q <= dexp_n;
        res_q <= cfg[3:2];
      end else if (stop_cv) busy <= 1'b0;
    end
  end

  assign irq     = coco && aien;
  assign bus_err = bus_rd && bad;

  always_comb begin
    bus_rdata = '0;
    if (!bad)
      case (bus_addr)
        A_CH:    bus_rdata = {24'd0, aien, 2'b00, chan};
        A_ST:    bus_rdata = {31'd0, coco};
        A_RES:   bus_rdata = 32'(result);
        A_CFG:   bus_rdata = {15'd0, cfg};
        A_GC:    bus_rdata = {24'd0, gctl};
        A_GS:    bus_rdata = {30'd0, calf, 1'b0};
        default: bus_rdata = '0;
      endcase
  end

  a_r2_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cv |=> !busy);
  a_r6_mask8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cal_run && res_q == 2'd0 && (!coco || cfg[16] || rd_res)) |=> (result >> 8) == '0);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res && !done) |=> !coco);
  a_r9_keep_unread: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cal_run && coco && !cfg[16] && !rd_res) |=> $stable(result));
  a_r11_cal_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cal_run) |=> $stable(result) && coco);
  a_r12_busy_cal_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req && busy && !done) |=> calf && !gctl[7]);
endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = 8'h0C;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_err, smp_take, irq;
  logic [11:0] feed [4];
  logic [1:0] scnt = 2'd0;
  wire [11:0] sample_data = feed[scnt];

  int total = 0, bad = 0, cyc = 0, t_start = 0;
  int lat_q[$], val_q[$];
  string tag_q[$];
  logic irq_d = 1'b0;

  adc_seq_ctrl uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .sample_data(sample_data), .smp_take(smp_take), .irq(irq));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (smp_take) scnt <= scnt + 2'd1;

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    irq_d <= irq;
    if (rst_n && irq && !irq_d) begin
      if (lat_q.size() == 0) chk(1, 0, "R7 unexpected irq");
      else begin
        string t;
        t = tag_q.pop_front();
        chk(cyc - t_start, lat_q.pop_front(), {t, " latency"});
        chk(int'(bus_rdata), val_q.pop_front(), {t, " result"});
      end
    end
  end

  task automatic setd(input logic [11:0] a, b, c, d);
    feed[0] = a; feed[1] = b; feed[2] = c; feed[3] = d;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 8'h0C;
  endtask
  task automatic rd(input logic [7:0] a, output int v, output logic e);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1; v = int'(bus_rdata); e = bus_err;
    @(negedge clk); bus_rd = 1'b0; bus_addr = 8'h0C;
  endtask
  task automatic peek(input logic [7:0] a, output int v);
    bus_addr = a; #1; v = int'(bus_rdata); bus_addr = 8'h0C;
  endtask
  task automatic sb_go(input logic [7:0] a, input logic [31:0] d, input int lat,
                       input int val, input string tag);
    int n, v; logic e;
    lat_q.push_back(lat); val_q.push_back(val); tag_q.push_back(tag);
    wr(a, d); t_start = cyc;
    n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    rd(8'h0C, v, e);
    peek(8'h08, v);
    chk(v, 0, {tag, " R8 flag cleared by read"});
  endtask
  task automatic conv(input int cfgv, input int gcv, input int lat, input int val,
                      input string tag);
    wr(8'h14, cfgv); wr(8'h18, gcv);
    sb_go(8'h00, 32'h83, lat, val, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v; logic e;
    setd(12'h0, 12'h0, 12'h0, 12'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    peek(8'h00, v); chk(v, 32'h1F, "reset R2 channel idle");
    peek(8'h08, v); chk(v, 0, "reset R7 flag");
    chk(int'(irq), 0, "reset R7 irq");

    rd(8'h02, v, e); chk(int'(e), 1, "R1 unaligned rejected"); chk(v, 0, "R1 rejected data");
    rd(8'h34, v, e); chk(int'(e), 1, "R1 high offset rejected");
    rd(8'h30, v, e); chk(int'(e), 0, "R1 0x30 accepted");

    setd(12'hABC, 12'hABC, 12'hABC, 12'hABC);
    conv(32'h8, 0, 34, 12'hABC, "R3 R6 12bit");
    conv(32'h0, 0, 34, 12'hBC, "R6 8bit");
    setd(12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF);
    conv(32'h214, 0, 52, 12'h3FF, "R4 adder21 R6 10bit");
    setd(12'h555, 12'h555, 12'h555, 12'h555);
    conv(32'h108, 0, 36, 12'h555, "R4 adder5");
    setd(12'd10, 12'd20, 12'd30, 12'd41);
    conv(32'h318, 32'h20, 206, 25, "R5 avg4 R4 adder25");
    setd(12'h7FF, 12'h7FF, 12'h7FF, 12'h7FF);
    conv(32'hC008, 32'h20, 902, 12'h7FF, "R5 avg32");
    setd(12'h123, 12'h123, 12'h123, 12'h123);
    conv(32'h69, 0, 544, 12'h123, "R3 div16");

    setd(12'h0F0, 12'h0F0, 12'h0F0, 12'h0F0);
    wr(8'h14, 32'h8);
    wr(8'h00, 32'h81);
    repeat (10) @(negedge clk);
    sb_go(8'h00, 32'h81, 34, 12'h0F0, "R2 restart");
    wr(8'h00, 32'h81);
    repeat (10) @(negedge clk);
    wr(8'h00, 32'h9F);
    repeat (60) @(negedge clk);
    chk(int'(irq), 0, "R2 abort no irq");
    peek(8'h08, v); chk(v, 0, "R2 abort no flag");

    setd(12'h111, 12'h111, 12'h111, 12'h111);
    wr(8'h00, 32'h03); repeat (40) @(negedge clk);
    setd(12'h222, 12'h222, 12'h222, 12'h222);
    wr(8'h00, 32'h03); repeat (40) @(negedge clk);
    rd(8'h0C, v, e); chk(v, 12'h111, "R9 unread kept");
    wr(8'h14, 32'h10008);
    setd(12'h333, 12'h333, 12'h333, 12'h333);
    wr(8'h00, 32'h03); repeat (40) @(negedge clk);
    setd(12'h444, 12'h444, 12'h444, 12'h444);
    wr(8'h00, 32'h03); repeat (40) @(negedge clk);
    rd(8'h0C, v, e); chk(v, 12'h444, "R9 overwrite");

    wr(8'h14, 32'h8);
    setd(12'h5A5, 12'h5A5, 12'h5A5, 12'h5A5);
    wr(8'h00, 32'h03); repeat (40) @(negedge clk);
    setd(12'h6B6, 12'h6B6, 12'h6B6, 12'h6B6);
    wr(8'h00, 32'h03);
    repeat (33) @(negedge clk);
    bus_rd = 1'b1; #1;
    chk(int'(bus_rdata), 12'h5A5, "R8 coincident read old");
    @(negedge clk); bus_rd = 1'b0;
    chk(int'(bus_rdata), 12'h6B6, "R8 coincident new stored");
    peek(8'h08, v); chk(v, 1, "R8 coincident flag kept");
    rd(8'h0C, v, e);

    setd(12'h101, 12'h101, 12'h101, 12'h101);
    wr(8'h18, 32'h40);
    wr(8'h00, 32'h02);
    repeat (33) @(negedge clk);
    peek(8'h08, v); chk(v, 0, "R10 first not yet");
    @(negedge clk);
    peek(8'h08, v); chk(v, 1, "R10 first done");
    setd(12'h202, 12'h202, 12'h202, 12'h202);
    rd(8'h0C, v, e); chk(v, 12'h101, "R10 first result");
    repeat (31) @(negedge clk);
    peek(8'h08, v); chk(v, 0, "R10 second not yet");
    @(negedge clk);
    peek(8'h08, v); chk(v, 1, "R10 auto restart done");
    rd(8'h0C, v, e); chk(v, 12'h202, "R10 second result");
    wr(8'h00, 32'h1F);
    repeat (80) @(negedge clk);
    peek(8'h08, v); chk(v, 0, "R10 stopped");
    wr(8'h18, 32'h0);

    setd(12'h0AA, 12'h0AA, 12'h0AA, 12'h0AA);
    wr(8'h00, 32'h03);
    repeat (5) @(negedge clk);
    wr(8'h18, 32'h80);
    peek(8'h1C, v); chk(v, 2, "R12 fail flag");
    peek(8'h18, v); chk(v, 0, "R12 cal bit cleared");
    repeat (40) @(negedge clk);
    rd(8'h0C, v, e); chk(v, 12'h0AA, "R12 conversion unaffected");

    setd(12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF);
    wr(8'h00, 32'h9F);
    sb_go(8'h18, 32'h80, 902, 12'h0AA, "R11 calibration");
    peek(8'h18, v); chk(v, 0, "R11 cal bit cleared");
    peek(8'h1C, v); chk(v, 0, "R11 pass clears fail");

    repeat (5) @(negedge clk);
    chk(lat_q.size(), 0, "R7 all completions seen");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule